// File: doc/BRIEF.md
# Register Load Instruction Executor

This block is a small sequential execution unit for the data-movement subset of an 8-bit accumulator CPU. It keeps seven general byte registers plus a flag byte, a 16-bit stack pointer and a 16-bit program counter. It pulls opcodes and immediate bytes over a byte-wide synchronous memory port and executes three kinds of load. The first is a copy between registers, where either side may be the byte in memory addressed by the H:L pair. The second loads an 8-bit immediate into a register or into memory at H:L. The third loads a 16-bit immediate into a register pair or into the stack pointer.

Each completed instruction produces a one-cycle completion pulse. With it come the opcode, the number of machine cycles the instruction used (one per bus transfer), and a marker for the halt opcode or for an opcode outside the supported set. The architectural state is visible on the ports so that an enclosing core or a test harness can follow it.

Top module: `ldx_core`

## Requirements
- R1: For opcodes 0x40 to 0x7F other than 0x76, bits 5:3 name the destination and bits 2:0 the source. The code map is 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at address {H,L}, 7=A. The instruction copies the source value to the destination.
- R2: Opcode 0x76 copies nothing and makes no memory transfer. It retires with `halt_o` high and a cost of 1.
- R3: `mcyc_o` on retirement gives the instruction's machine cycles, which equal its bus transfers. The costs are: register-to-register copy 1; a copy with a memory operand 2; immediate byte to a register 2; immediate byte to memory 3; 16-bit immediate 3; halt or unsupported 1.
- R4: Opcodes 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E and 0x3E load the following byte into B, C, D, E, H, L and A respectively.
- R5: Opcode 0x36 writes the following byte to memory at {H,L}.
- R6: Opcodes 0x01, 0x11, 0x21 and 0x31 load BC, DE, HL and SP. The first immediate byte goes to the low half (C, E, L, SP[7:0]) and the second goes to the high half.
- R7: The program counter increases by one for each opcode or immediate byte fetched and wraps from 0xFFFF to 0x0000.
- R8: Reset makes every register 0, SP 0, PC equal to `RESET_PC` and F equal to `F_RESET`. No instruction ever changes F.
- R9: An opcode outside the supported set retires with `bad_o` high for one cycle. All registers and SP stay unchanged; only PC advances by one.
- R10: `done_o` is high for exactly one cycle per instruction. `op_o`, `mcyc_o`, `halt_o` and `bad_o` are valid in that cycle, and `regs_o`, `sp_o` and `pc_o` already show the instruction's results. `regs_o[8*k +: 8]` holds code k, and slot 6 holds F.
- R11: Read data is taken on `mem_rdata_i` one cycle after a `mem_rd_o` request. A read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | 16 | Memory address for read or write |
| mem_rd_o | output | 1 | Read request; data is returned the next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| done_o | output | 1 | Instruction retired (one-cycle pulse) |
| op_o | output | 8 | Opcode of the retired instruction |
| mcyc_o | output | 2 | Machine cycles used by the retired instruction |
| halt_o | output | 1 | Retired instruction was the halt opcode |
| bad_o | output | 1 | Retired opcode is not supported |
| regs_o | output | 64 | Register bytes by code; slot 6 is F |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |

## Verification
The assertions assume that the memory behaves as a plain synchronous byte store: it returns the addressed byte exactly one cycle after a read request and applies a write at the clock edge where the strobe is high. They also assume that reset is held for at least one edge before execution begins. The bench models memory as an array of this kind, so the port contract holds by construction. The array aliases addresses modulo its size, and the reference model uses the same aliasing, so any H:L value or program counter, including the wrap past 0xFFFF, stays within those assumptions. The bench fills memory and computes the expected stream of retirements before it releases reset, and it never drives `mem_rdata_i` outside that protocol.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NREG    = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int MCYC_W  = 2;
    localparam int NPAIR   = 4;
    localparam int PAIR_W  = $clog2(NPAIR);

    localparam logic [RIDX_W-1:0] CODE_MEM = 3'd6;
    localparam logic [PAIR_W-1:0] PAIR_SP  = 2'd3;
    localparam logic [BYTE_W-1:0] OP_HALT  = 8'h76;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MCYC_W-1:0] mcyc_t;

    typedef enum logic [2:0] {
        K_MOVE,
        K_HALT,
        K_IMM8,
        K_IMM16,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_MEMRD,
        S_IMM8,
        S_IMMLO,
        S_IMMHI
    } state_e;

    typedef struct packed {
        kind_e               kind;
        logic [RIDX_W-1:0]   dst;
        logic [RIDX_W-1:0]   src;
        logic [PAIR_W-1:0]   pair;
        logic                dst_mem;
        logic                src_mem;
        mcyc_t               cost;
    } dec_s;

    function automatic kind_e classify(byte_t op);
        kind_e k;
        if (op == OP_HALT)                                k = K_HALT;
        else if (op[7:6] == 2'b01)                        k = K_MOVE;
        else if (op[7:6] == 2'b00 && op[2:0] == 3'b110)   k = K_IMM8;
        else if (op[7:6] == 2'b00 && op[3:0] == 4'b0001)  k = K_IMM16;
        else                                              k = K_BAD;
        return k;
    endfunction

    function automatic mcyc_t cost_of(kind_e k, logic dmem, logic smem);
        mcyc_t c;
        case (k)
            K_MOVE:  c = (dmem || smem) ? mcyc_t'(2) : mcyc_t'(1);
            K_IMM8:  c = dmem ? mcyc_t'(3) : mcyc_t'(2);
            K_IMM16: c = mcyc_t'(3);
            default: c = mcyc_t'(1);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ldx_decode.sv
module ldx_decode
    import ldx_pkg::*;
(
    input  byte_t op_i,
    output dec_s  dec_o
);
    kind_e kind;
    logic  dmem;
    logic  smem;

    always_comb begin
        kind = classify(op_i);
        dmem = (op_i[5:3] == CODE_MEM);
        smem = (op_i[2:0] == CODE_MEM);
        dec_o.kind    = kind;
        dec_o.dst     = op_i[5:3];
        dec_o.src     = op_i[2:0];
        dec_o.pair    = op_i[5:4];
        dec_o.dst_mem = dmem;
        dec_o.src_mem = smem;
        dec_o.cost    = cost_of(kind, dmem, smem);
    end
endmodule

// File: rtl/ldx_regfile.sv
module ldx_regfile
    import ldx_pkg::*;
#(
    parameter byte_t F_RESET = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en_i,
    input  logic [RIDX_W-1:0]      wr_idx_i,
    input  byte_t                  wr_data_i,
    input  logic                   sp_lo_we_i,
    input  logic                   sp_hi_we_i,
    input  byte_t                  sp_data_i,
    input  logic [RIDX_W-1:0]      rd_idx_i,
    output byte_t                  rd_data_o,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output word_t                  sp_o
);
    byte_t slot [NREG];
    word_t sp_q;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == int'(CODE_MEM)) begin : g_flag
            byte_t f_q;
            always_ff @(posedge clk) begin
                if (rst) f_q <= F_RESET;
            end
            assign slot[i] = f_q;
        end else begin : g_gpr
            byte_t r_q;
            always_ff @(posedge clk) begin
                if (rst)
                    r_q <= '0;
                else if (wr_en_i && wr_idx_i == RIDX_W'(i))
                    r_q <= wr_data_i;
            end
            assign slot[i] = r_q;
        end
        assign regs_o[i*BYTE_W +: BYTE_W] = slot[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else begin
            if (sp_lo_we_i) sp_q[BYTE_W-1:0]      <= sp_data_i;
            if (sp_hi_we_i) sp_q[WORD_W-1:BYTE_W] <= sp_data_i;
        end
    end

    assign rd_data_o = slot[rd_idx_i];
    assign sp_o      = sp_q;
endmodule

// File: rtl/ldx_core.sv
module ldx_core
    import ldx_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000,
    parameter logic [7:0]  F_RESET  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr_o,
    output logic        mem_rd_o,
    output logic        mem_we_o,
    output logic [7:0]  mem_wdata_o,
    input  logic [7:0]  mem_rdata_i,
    output logic        done_o,
    output logic [7:0]  op_o,
    output logic [1:0]  mcyc_o,
    output logic        halt_o,
    output logic        bad_o,
    output logic [63:0] regs_o,
    output logic [15:0] sp_o,
    output logic [15:0] pc_o
);
    state_e state_q, state_d;
    byte_t  ir_q;
    word_t  pc_q;
    byte_t  op_cur;
    dec_s   dec;

    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    byte_t             wr_data;
    logic              sp_lo_we, sp_hi_we;
    byte_t             rf_rd;
    word_t             hl;
    logic              pc_inc;

    logic  fin, fin_halt, fin_bad;
    logic  done_q, halt_q, bad_q;
    byte_t op_q;
    mcyc_t mcyc_q;

    assign op_cur = (state_q == S_DECODE) ? mem_rdata_i : ir_q;

    ldx_decode u_dec (
        .op_i  (op_cur),
        .dec_o (dec)
    );

    ldx_regfile #(.F_RESET(F_RESET)) u_rf (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .sp_lo_we_i (sp_lo_we),
        .sp_hi_we_i (sp_hi_we),
        .sp_data_i  (mem_rdata_i),
        .rd_idx_i   (dec.src),
        .rd_data_o  (rf_rd),
        .regs_o     (regs_o),
        .sp_o       (sp_o)
    );

    assign hl = {regs_o[4*BYTE_W +: BYTE_W], regs_o[5*BYTE_W +: BYTE_W]};

    always_comb begin
        state_d     = state_q;
        mem_addr_o  = pc_q;
        mem_rd_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_wdata_o = rf_rd;
        pc_inc      = 1'b0;
        wr_en       = 1'b0;
        wr_idx      = dec.dst;
        wr_data     = mem_rdata_i;
        sp_lo_we    = 1'b0;
        sp_hi_we    = 1'b0;
        fin         = 1'b0;
        fin_halt    = 1'b0;
        fin_bad     = 1'b0;
        case (state_q)
            S_FETCH: begin
                mem_rd_o = 1'b1;
                pc_inc   = 1'b1;
                state_d  = S_DECODE;
            end
            S_DECODE: begin
                case (dec.kind)
                    K_MOVE: begin
                        if (dec.src_mem) begin
                            mem_rd_o   = 1'b1;
                            mem_addr_o = hl;
                            state_d    = S_MEMRD;
                        end else begin
                            if (dec.dst_mem) begin
                                mem_we_o   = 1'b1;
                                mem_addr_o = hl;
                            end else begin
                                wr_en   = 1'b1;
                                wr_data = rf_rd;
                            end
                            fin     = 1'b1;
                            state_d = S_FETCH;
                        end
                    end
                    K_HALT: begin
                        fin      = 1'b1;
                        fin_halt = 1'b1;
                        state_d  = S_FETCH;
                    end
                    K_IMM8, K_IMM16: begin
                        mem_rd_o = 1'b1;
                        pc_inc   = 1'b1;
                        state_d  = (dec.kind == K_IMM8) ? S_IMM8 : S_IMMLO;
                    end
                    default: begin
                        fin     = 1'b1;
                        fin_bad = 1'b1;
                        state_d = S_FETCH;
                    end
                endcase
            end
            S_MEMRD: begin
                wr_en   = 1'b1;
                fin     = 1'b1;
                state_d = S_FETCH;
            end
            S_IMM8: begin
                if (dec.dst_mem) begin
                    mem_we_o    = 1'b1;
                    mem_addr_o  = hl;
                    mem_wdata_o = mem_rdata_i;
                end else begin
                    wr_en = 1'b1;
                end
                fin     = 1'b1;
                state_d = S_FETCH;
            end
            S_IMMLO: begin
                if (dec.pair == PAIR_SP) sp_lo_we = 1'b1;
                else                     wr_en    = 1'b1;
                wr_idx   = {dec.pair, 1'b1};
                mem_rd_o = 1'b1;
                pc_inc   = 1'b1;
                state_d  = S_IMMHI;
            end
            S_IMMHI: begin
                if (dec.pair == PAIR_SP) sp_hi_we = 1'b1;
                else                     wr_en    = 1'b1;
                wr_idx  = {dec.pair, 1'b0};
                fin     = 1'b1;
                state_d = S_FETCH;
            end
            default: state_d = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH;
            ir_q    <= '0;
            pc_q    <= RESET_PC;
            done_q  <= 1'b0;
            halt_q  <= 1'b0;
            bad_q   <= 1'b0;
            op_q    <= '0;
            mcyc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_DECODE) ir_q <= mem_rdata_i;
            pc_q    <= pc_q + word_t'(pc_inc);
            done_q  <= fin;
            halt_q  <= fin_halt;
            bad_q   <= fin_bad;
            if (fin) begin
                op_q   <= op_cur;
                mcyc_q <= dec.cost;
            end
        end
    end

    assign done_o = done_q;
    assign halt_o = halt_q;
    assign bad_o  = bad_q;
    assign op_o   = op_q;
    assign mcyc_o = mcyc_q;
    assign pc_o   = pc_q;
endmodule

// File: rtl/ldx_core_chk.sv
module ldx_core_chk #(
    parameter logic [7:0] F_RESET = 8'h00
) (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd_o,
    input logic        mem_we_o,
    input logic        done_o,
    input logic [7:0]  op_o,
    input logic [1:0]  mcyc_o,
    input logic        halt_o,
    input logic        bad_o,
    input logic [63:0] regs_o,
    input logic [15:0] sp_o
);
    logic [2:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= '0;
        else if (done_o) acc_q <= 3'(mem_rd_o || mem_we_o);
        else             acc_q <= acc_q + 3'(mem_rd_o || mem_we_o);
    end

    a_r11_rd_we_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_we_o));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r3_cost_equals_bus: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ({1'b0, mcyc_o} == acc_q));

    a_r8_flag_untouched: assert property (@(posedge clk) disable iff (rst)
        regs_o[55:48] == F_RESET);

    a_r2_halt_opcode: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> (done_o && op_o == 8'h76 && mcyc_o == 2'd1));

    a_r9_bad_keeps_state: assert property (@(posedge clk) disable iff (rst)
        bad_o |-> (done_o && $stable(regs_o) && $stable(sp_o)));
endmodule

bind ldx_core ldx_core_chk #(.F_RESET(F_RESET)) u_ldx_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_rd_o (mem_rd_o),
    .mem_we_o (mem_we_o),
    .done_o   (done_o),
    .op_o     (op_o),
    .mcyc_o   (mcyc_o),
    .halt_o   (halt_o),
    .bad_o    (bad_o),
    .regs_o   (regs_o),
    .sp_o     (sp_o)
);

// File: tb/test_ldx_core.sv
module test_ldx_core;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] START_PC   = 16'hFFFC;
    localparam logic [7:0]  FLAG_INIT  = 8'hB0;
    localparam int          MEM_SZ     = 4096;
    localparam int          N_INSTR    = 400;
    localparam int          WD_LIMIT   = 20000;

    typedef struct packed {
        logic [7:0]  op;
        logic [1:0]  mcyc;
        logic        halt;
        logic        bad;
        logic [63:0] regs;
        logic [15:0] sp;
        logic [15:0] pc;
    } exp_s;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        done, halt, bad;
    logic [7:0]  op;
    logic [1:0]  mcyc;
    logic [63:0] regs;
    logic [15:0] sp, pc;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] dmem    [0:MEM_SZ-1];
    logic [7:0] ref_mem [0:MEM_SZ-1];
    logic [7:0] rr [0:7];
    logic [15:0] rsp, rpc;
    exp_s q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ldx_core #(.RESET_PC(START_PC), .F_RESET(FLAG_INIT)) i_ldx_core (
        .clk(clk), .rst(rst),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .done_o(done), .op_o(op), .mcyc_o(mcyc), .halt_o(halt), .bad_o(bad),
        .regs_o(regs), .sp_o(sp), .pc_o(pc)
    );

    always @(posedge clk) begin
        if (mem_we) dmem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= dmem[mem_addr[11:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic string tag_of(logic [7:0] o);
        if (o == 8'h76)                             return "R2";
        if (o[7:6] == 2'b01)                        return "R1";
        if (o == 8'h36)                             return "R5";
        if (o[7:6] == 2'b00 && o[2:0] == 3'b110)    return "R4";
        if (o[7:6] == 2'b00 && o[3:0] == 4'b0001)   return "R6";
        return "R9";
    endfunction

    function automatic logic [63:0] pack_regs();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = rr[k];
        return v;
    endfunction

    function automatic logic [7:0] mrd(logic [15:0] a);
        return ref_mem[a[11:0]];
    endfunction

    // Reference model: one instruction, computed from R1..R9
    task automatic ref_step();
        exp_s        e;
        logic [7:0]  o, b0, b1;
        logic [2:0]  d, s;
        logic [15:0] hl;
        o = mrd(rpc); rpc = rpc + 16'd1;
        d = o[5:3]; s = o[2:0];
        hl = {rr[4], rr[5]};
        e.op = o; e.halt = 1'b0; e.bad = 1'b0; e.mcyc = 2'd1;
        if (o == 8'h76) begin
            e.halt = 1'b1;
        end else if (o[7:6] == 2'b01) begin
            if (s == 3'd6)      begin rr[d] = mrd(hl);        e.mcyc = 2'd2; end
            else if (d == 3'd6) begin ref_mem[hl[11:0]] = rr[s]; e.mcyc = 2'd2; end
            else                rr[d] = rr[s];
        end else if (o[7:6] == 2'b00 && s == 3'd6) begin
            b0 = mrd(rpc); rpc = rpc + 16'd1;
            if (d == 3'd6) begin ref_mem[hl[11:0]] = b0; e.mcyc = 2'd3; end
            else           begin rr[d] = b0;             e.mcyc = 2'd2; end
        end else if (o[7:6] == 2'b00 && o[3:0] == 4'b0001) begin
            b0 = mrd(rpc); rpc = rpc + 16'd1;
            b1 = mrd(rpc); rpc = rpc + 16'd1;
            e.mcyc = 2'd3;
            case (o[5:4])
                2'd0: begin rr[0] = b1; rr[1] = b0; end
                2'd1: begin rr[2] = b1; rr[3] = b0; end
                2'd2: begin rr[4] = b1; rr[5] = b0; end
                default: rsp = {b1, b0};
            endcase
        end else begin
            e.bad = 1'b1;
        end
        e.regs = pack_regs(); e.sp = rsp; e.pc = rpc;
        q.push_back(e);
    endtask

    // Monitor: pops expected retirements and compares
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            check(!(mem_rd && mem_we), "R11", "read and write together",
                  {62'd0, mem_rd, mem_we}, 64'd0);
            if (done && prev_done)
                check(1'b0, "R10", "done longer than one cycle", 64'd1, 64'd0);
            if (done && q.size() > 0) begin
                exp_s e;
                string t;
                e = q.pop_front();
                t = tag_of(e.op);
                check(op == e.op && halt == e.halt && bad == e.bad, t, "op/halt/bad",
                      {54'd0, op, halt, bad}, {54'd0, e.op, e.halt, e.bad});
                check(mcyc == e.mcyc, "R3", "machine cycles", 64'(mcyc), 64'(e.mcyc));
                check(regs == e.regs, t, "registers (R8 slot 6 is F)", regs, e.regs);
                check(sp == e.sp, "R6", "stack pointer", 64'(sp), 64'(e.sp));
                check(pc == e.pc, "R7", "program counter", 64'(pc), 64'(e.pc));
            end
            prev_done = done;
        end
    end

    initial begin
        logic [15:0] lf;
        int a, cyc, bad_bytes, first_bad;
        for (int i = 0; i < MEM_SZ; i++) dmem[i] = 8'h00;
        // Directed prefix, starting just below the wrap point (R7)
        dmem[12'hFFC] = 8'h21; dmem[12'hFFD] = 8'h00; dmem[12'hFFE] = 8'h08; // HL=0800
        dmem[12'hFFF] = 8'h06; dmem[12'h000] = 8'h5A;                       // B=5A across wrap
        dmem[12'h001] = 8'h70;                                               // (HL)=B
        dmem[12'h002] = 8'h36; dmem[12'h003] = 8'hC3;                        // (HL)=C3
        dmem[12'h004] = 8'h7E;                                               // A=(HL)
        dmem[12'h005] = 8'h76;                                               // halt
        dmem[12'h006] = 8'h40;                                               // B=B
        dmem[12'h007] = 8'h31; dmem[12'h008] = 8'h34; dmem[12'h009] = 8'h12; // SP
        dmem[12'h00A] = 8'h01; dmem[12'h00B] = 8'hCD; dmem[12'h00C] = 8'hAB; // BC
        dmem[12'h00D] = 8'h11; dmem[12'h00E] = 8'hEF; dmem[12'h00F] = 8'hBE; // DE
        dmem[12'h010] = 8'h0E; dmem[12'h011] = 8'h11;
        dmem[12'h012] = 8'h16; dmem[12'h013] = 8'h22;
        dmem[12'h014] = 8'h1E; dmem[12'h015] = 8'h33;
        dmem[12'h016] = 8'h26; dmem[12'h017] = 8'h09;
        dmem[12'h018] = 8'h2E; dmem[12'h019] = 8'h00;
        dmem[12'h01A] = 8'h3E; dmem[12'h01B] = 8'h44;
        dmem[12'h01C] = 8'h77;                                               // (HL)=A
        dmem[12'h01D] = 8'hCB; dmem[12'h01E] = 8'h00;                        // unsupported
        dmem[12'h01F] = 8'h5F; dmem[12'h020] = 8'h4A;
        // Pseudo-random mixture biased toward the supported classes
        lf = 16'hACE1;
        for (int p = 12'h021; p < 12'h400; p++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[9:8])
                2'd0, 2'd1: dmem[p] = {2'b01, lf[5:0]};
                2'd2:       dmem[p] = {2'b00, lf[5:3], 3'b110};
                default:    dmem[p] = lf[7] ? {2'b00, lf[5:4], 4'b0001} : lf[7:0];
            endcase
        end
        for (int i = 0; i < MEM_SZ; i++) ref_mem[i] = dmem[i];
        for (int k = 0; k < 8; k++) rr[k] = 8'h00;
        rr[6] = FLAG_INIT; rsp = 16'h0000; rpc = START_PC;
        for (int n = 0; n < N_INSTR; n++) ref_step();

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(regs == {8'h00, FLAG_INIT, 48'd0}, "R8", "reset registers",
              regs, {8'h00, FLAG_INIT, 48'd0});
        check(sp == 16'h0000 && pc == START_PC, "R8", "reset sp/pc",
              {32'd0, sp, pc}, {32'd0, 16'h0000, START_PC});
        check(done == 1'b0, "R10", "no retirement in reset", 64'(done), 64'd0);
        rst = 1'b0;

        cyc = 0;
        while (q.size() > 0 && cyc < WD_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (q.size() > 0)
            check(1'b0, "R10", "watchdog: retirements missing", 64'(q.size()), 64'd0);
        repeat (6) @(negedge clk);

        // R1/R5: memory stores match the reference image
        bad_bytes = 0; first_bad = -1;
        for (a = 0; a < MEM_SZ; a++)
            if (dmem[a] !== ref_mem[a]) begin
                bad_bytes++;
                if (first_bad < 0) first_bad = a;
            end
        check(bad_bytes == 0, "R5", "memory image mismatches (R1 stores)",
              64'(bad_bytes), 64'd0);
        if (first_bad >= 0)
            $display("  first differing address %0h", first_bad);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule